// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers a parameterised group of peripheral interrupt lines (32 by default) into one request for a parent interrupt controller. Each line passes through a two-flop synchroniser. A build-time switch picks one of two variants. In the latched variant, a rising edge on a line sets a sticky pending bit, and software acknowledges it through a write-one-to-clear register. In the level variant, the pending bits are the synchronised input levels. The level variant has no clear register, so its register map is shorter.

Software never reads and rewrites the mask. It masks sources through a write-one-to-set register and unmasks them through a write-one-to-clear register, and it can read the current mask back. The request output is raised when any pending bit is unmasked. A separate wake-enable register selects which pending bits drive a wake output, and the normal mask has no effect on that output. Register reads are combinational from the address. Writes take effect at the clock edge where `reg_we` is high.

Byte offsets in the latched variant:
- status: 0x00
- clear: 0x08
- mask readback: 0x0C
- mask set: 0x10
- mask clear: 0x14
- wake enable: 0x18

Byte offsets in the level variant:
- status: 0x00
- mask readback: 0x04
- mask set: 0x08
- mask clear: 0x0C
- wake enable: 0x10

Write-only and unmapped offsets read as zero.

Top module: `l2irq_aggr`

## Requirements
- R1: After reset the mask reads all ones, status and wake enable read zero, and `irq_out` and `wake_out` are low.
- R2: Writing the mask-set offset (0x10 latched, 0x08 level) sets every mask bit written as 1 and leaves bits written as 0 unchanged.
- R3: Writing the mask-clear offset (0x14 latched, 0x0C level) clears every mask bit written as 1 and leaves bits written as 0 unchanged.
- R4: The mask readback offset (0x0C latched, 0x04 level) returns the current mask, where 1 means masked. Write-only and unmapped offsets read zero.
- R5: Latched variant: a source that rises before clock edge k sets its status bit from edge k+2 onward, and the bit stays set after the source falls.
- R6: Latched variant: writing 1 to a bit at offset 0x08 clears that status bit. A rising edge detected in the same cycle as the clear keeps the bit set.
- R7: Level variant: status at 0x00 equals the source levels delayed by two clocks. The variant has no clear register, so a write to 0x08 acts as a mask-set write.
- R8: `irq_out` is high exactly when some status bit is set while its mask bit is 0.
- R9: `wake_out` is high exactly when some status bit is set while its wake-enable bit is 1, regardless of the mask. Wake enable is read/write at 0x18 (latched) and 0x10 (level).
- R10: Writes to the status offset have no effect in either variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Peripheral interrupt lines, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for `reg_addr` |
| irq_out | output | 1 | Combined request to the parent controller |
| wake_out | output | 1 | Wake request from wake-enabled pending bits |

## Verification
The assertions assume one register access per cycle. They also assume that `reg_wdata` is meaningful only while `reg_we` is high, so a mask-set and a mask-clear never arrive in the same cycle. The bench drives at most one write per cycle on each instance and changes inputs only on falling edges, so the synchronisers see clean levels. The same-cycle case of a new edge and a clear is reached deliberately, by timing the clear write to the cycle in which the rise is detected.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_STATUS,
        REG_CLEAR,
        REG_MASK,
        REG_MSET,
        REG_MCLR,
        REG_WAKE
    } reg_sel_e;

    function automatic reg_sel_e decode_reg(input logic latched, input logic [7:0] off);
        reg_sel_e r;
        r = REG_NONE;
        if (latched) begin
            case (off)
                8'h00: r = REG_STATUS;
                8'h08: r = REG_CLEAR;
                8'h0C: r = REG_MASK;
                8'h10: r = REG_MSET;
                8'h14: r = REG_MCLR;
                8'h18: r = REG_WAKE;
                default: r = REG_NONE;
            endcase
        end else begin
            case (off)
                8'h00: r = REG_STATUS;
                8'h04: r = REG_MASK;
                8'h08: r = REG_MSET;
                8'h0C: r = REG_MCLR;
                8'h10: r = REG_WAKE;
                default: r = REG_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/l2irq_status.sv
module l2irq_status #(
    parameter int N       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] status
);
    if (LATCHED) begin : g_latched
        logic [N-1:0] prev_q;
        logic [N-1:0] status_q;
        logic [N-1:0] rise;

        assign rise = lvl & ~prev_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prev_q   <= '0;
                status_q <= '0;
            end else begin
                prev_q   <= lvl;
                status_q <= (status_q & ~(clr_we ? clr_bits : '0)) | rise;
            end
        end

        assign status = status_q;

        p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_we |=> ((status_q & $past(status_q)) == $past(status_q)));
        p_rise_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (|rise) |=> ((status_q & $past(rise)) == $past(rise)));
        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_we |=> ((status_q & $past(clr_bits) & ~$past(rise)) == '0));
    end else begin : g_level
        assign status = lvl;
    end
endmodule

// File: rtl/l2irq_mask.sv
module l2irq_mask #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] mask
);
    logic [N-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)      mask_q <= '1;
        else if (set_we) mask_q <= mask_q | wbits;
        else if (clr_we) mask_q <= mask_q & ~wbits;
    end

    assign mask = mask_q;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
    p_set_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask_q & ~$past(wbits)) == ($past(mask_q) & ~$past(wbits))));
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask_q & $past(wbits)) == '0));
    p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask_q));
endmodule

// File: rtl/l2irq_aggr.sv
module l2irq_aggr
    import l2irq_pkg::*;
#(
    parameter int NUM_SRC     = 32,
    parameter int ADDR_W      = 5,
    parameter bit LATCHED     = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [NUM_SRC-1:0] reg_wdata,
    output logic [NUM_SRC-1:0] reg_rdata,
    output logic               irq_out,
    output logic               wake_out
);
    localparam logic [7:0] ADDR_PAD = 8'd0;

    reg_sel_e           sel;
    logic [NUM_SRC-1:0] lvl;
    logic [NUM_SRC-1:0] status;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] wake_en_q;
    logic               clr_we;
    logic               mset_we;
    logic               mclr_we;

    assign sel     = decode_reg(LATCHED, ADDR_PAD | 8'(reg_addr));
    assign clr_we  = reg_we && (sel == REG_CLEAR);
    assign mset_we = reg_we && (sel == REG_MSET);
    assign mclr_we = reg_we && (sel == REG_MCLR);

    l2irq_sync #(.N(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(src_in), .q(lvl));

    l2irq_status #(.N(NUM_SRC), .LATCHED(LATCHED)) u_status (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr_we(clr_we),
        .clr_bits(reg_wdata), .status(status));

    l2irq_mask #(.N(NUM_SRC)) u_mask (
        .clk(clk), .rst_n(rst_n), .set_we(mset_we), .clr_we(mclr_we),
        .wbits(reg_wdata), .mask(mask));

    always_ff @(posedge clk) begin
        if (!rst_n)                          wake_en_q <= '0;
        else if (reg_we && sel == REG_WAKE)  wake_en_q <= reg_wdata;
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            REG_STATUS: reg_rdata = status;
            REG_MASK:   reg_rdata = mask;
            REG_WAKE:   reg_rdata = wake_en_q;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq_out  = |(status & ~mask);
    assign wake_out = |(status & wake_en_q);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_out);
    p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (status != '0));
    p_wake_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_en_q == '0) |-> !wake_out);
endmodule

// File: tb/l2irq_aggr_test.sv
module l2irq_aggr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        la_we = 1'b0, lv_we = 1'b0;
    logic [4:0]  la_addr = '0, lv_addr = '0;
    logic [31:0] la_wd = '0, lv_wd = '0;
    logic [31:0] la_rd, lv_rd;
    logic        la_irq, la_wake, lv_irq, lv_wake;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    l2irq_aggr #(.LATCHED(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_we(la_we), .reg_addr(la_addr),
        .reg_wdata(la_wd), .reg_rdata(la_rd), .irq_out(la_irq), .wake_out(la_wake));
    l2irq_aggr #(.LATCHED(1'b0)) uut_lvl (
        .clk(clk), .rst_n(rst_n), .src_in(src), .reg_we(lv_we), .reg_addr(lv_addr),
        .reg_wdata(lv_wd), .reg_rdata(lv_rd), .irq_out(lv_irq), .wake_out(lv_wake));

    // behavioural reference state
    logic [31:0] m_s1, m_s2, m_prev, m_stl, m_mkl, m_wkl, m_mkv, m_wkv;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_stl <= '0;
            m_mkl <= '1; m_wkl <= '0; m_mkv <= '1; m_wkv <= '0;
        end else begin
            m_s1 <= src; m_s2 <= m_s1; m_prev <= m_s2;
            m_stl <= (m_stl & ~((la_we && la_addr == 5'h08) ? la_wd : 32'h0)) | (m_s2 & ~m_prev);
            if (la_we && la_addr == 5'h10) m_mkl <= m_mkl | la_wd;
            if (la_we && la_addr == 5'h14) m_mkl <= m_mkl & ~la_wd;
            if (la_we && la_addr == 5'h18) m_wkl <= la_wd;
            if (lv_we && lv_addr == 5'h08) m_mkv <= m_mkv | lv_wd;
            if (lv_we && lv_addr == 5'h0C) m_mkv <= m_mkv & ~lv_wd;
            if (lv_we && lv_addr == 5'h10) m_wkv <= lv_wd;
        end
    end

    function automatic logic [31:0] exp_rd(input bit lat, input logic [4:0] a);
        if (lat) begin
            case (a)
                5'h00: return m_stl;
                5'h0C: return m_mkl;
                5'h18: return m_wkl;
                default: return 32'h0;
            endcase
        end
        case (a)
            5'h00: return m_s2;
            5'h04: return m_mkv;
            5'h10: return m_wkv;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input bit lat, input logic [4:0] a);
        if (a == 5'h00) return lat ? "R5" : "R7";
        if ((lat && a == 5'h18) || (!lat && a == 5'h10)) return "R9";
        return "R4";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8", {31'h0, la_irq}, {31'h0, |(m_stl & ~m_mkl)});
            chk("R8", {31'h0, lv_irq}, {31'h0, |(m_s2 & ~m_mkv)});
            chk("R9", {31'h0, la_wake}, {31'h0, |(m_stl & m_wkl)});
            chk("R9", {31'h0, lv_wake}, {31'h0, |(m_s2 & m_wkv)});
            chk(tag_of(1'b1, la_addr), la_rd, exp_rd(1'b1, la_addr));
            chk(tag_of(1'b0, lv_addr), lv_rd, exp_rd(1'b0, lv_addr));
        end
    end

    task automatic wr_l(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); la_we = 1'b1; la_addr = a; la_wd = d;
        @(negedge clk); la_we = 1'b0;
    endtask
    task automatic wr_v(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); lv_we = 1'b1; lv_addr = a; lv_wd = d;
        @(negedge clk); lv_we = 1'b0;
    endtask
    task automatic rd_l(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); la_addr = a; #1; chk(tag, la_rd, exp);
    endtask
    task automatic rd_v(input string tag, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); lv_addr = a; #1; chk(tag, lv_rd, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1 reset state
        rd_l("R1", 5'h0C, 32'hFFFF_FFFF);
        rd_l("R1", 5'h00, 32'h0);
        rd_l("R1", 5'h18, 32'h0);
        rd_v("R1", 5'h04, 32'hFFFF_FFFF);
        chk("R1", {30'h0, la_irq, lv_irq}, 32'h0);
        // R3 then R2 on the latched map
        wr_l(5'h14, 32'h0000_00FF);
        rd_l("R3", 5'h0C, 32'hFFFF_FF00);
        wr_l(5'h10, 32'h0000_0003);
        rd_l("R2", 5'h0C, 32'hFFFF_FF03);
        // level map
        wr_v(5'h0C, 32'h0000_00F0);
        rd_v("R3", 5'h04, 32'hFFFF_FF0F);
        wr_v(5'h08, 32'h0000_0010);
        rd_v("R2", 5'h04, 32'hFFFF_FF1F);
        rd_l("R4", 5'h08, 32'h0);
        // R5 sticky edge capture
        @(negedge clk); src = 32'h0000_0005;
        repeat (4) @(negedge clk);
        src = 32'h0;
        repeat (3) @(negedge clk);
        rd_l("R5", 5'h00, 32'h0000_0005);
        chk("R8", {31'h0, la_irq}, 32'h1);
        rd_v("R7", 5'h00, 32'h0);
        // R10 status writes ignored
        wr_l(5'h00, 32'hFFFF_FFFF);
        rd_l("R10", 5'h00, 32'h0000_0005);
        wr_v(5'h00, 32'hFFFF_FFFF);
        rd_v("R10", 5'h00, 32'h0);
        // R6 clear
        wr_l(5'h08, 32'h0000_0004);
        rd_l("R6", 5'h00, 32'h0000_0001);
        chk("R8", {31'h0, la_irq}, 32'h0);
        // R6 rise in the same cycle as a clear
        @(negedge clk); src = 32'h0000_0010;
        @(negedge clk);
        @(negedge clk); la_we = 1'b1; la_addr = 5'h08; la_wd = 32'h0000_0011;
        @(negedge clk); la_we = 1'b0;
        rd_l("R6", 5'h00, 32'h0000_0010);
        // R9 wake independent of mask
        wr_l(5'h18, 32'h0000_0010);
        wr_l(5'h10, 32'h0000_0010);
        @(negedge clk); #1;
        chk("R9", {31'h0, la_wake}, 32'h1);
        chk("R8", {31'h0, la_irq}, 32'h0);
        // level: wake and level-follow
        wr_v(5'h10, 32'h0000_0020);
        @(negedge clk); src = 32'h0000_0030;
        repeat (3) @(negedge clk);
        #1;
        chk("R9", {31'h0, lv_wake}, 32'h1);
        rd_v("R7", 5'h00, 32'h0000_0030);
        // R7 no clear register: 0x08 is mask set
        wr_v(5'h08, 32'hFFFF_FFFF);
        rd_v("R7", 5'h04, 32'hFFFF_FFFF);
        rd_v("R7", 5'h00, 32'h0000_0030);
        @(negedge clk); src = 32'h0;
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule